// File: doc/BRIEF.md
# Interval timer register file

This block is the host-facing register front end of a three-channel programmable interval timer. The host issues single-byte reads and writes on a synchronous strobe with a 2-bit address. Offsets 0 to 2 reach the data ports of the channels and offset 3 is the control port, which accepts writes only. For every channel the block keeps the programmed control bits. It assembles one or two data bytes into a 16-bit reload value and tells the counting core about new configuration and new counts.

The counting cores live outside this block. Each core gets a one-cycle setup pulse when its control word is rewritten, and a one-cycle load pulse when a count write completes. Alongside these it receives a normalised mode, the BCD flag and the reload value. In return the block samples each core's live count, output level and null-count flag. It uses them for counter-latch and read-back commands: a count can be frozen in an output latch, and a status byte can be frozen in a status latch. Data-port reads return these latches in a defined order.

Top module: `ivt_host_regfile`

## Requirements
- R1: A control-port write whose select field (bits 7:6) names channel n < 3 and whose access field (bits 5:4) is nonzero stores bit 0 as the BCD flag, bits 3:1 as the mode and bits 5:4 as the access mode. It drives them on core_bcd and core_mode of channel n and raises core_setup[n] for exactly the cycle after the strobe.
- R2: A control-port write with access field 0 is a counter latch for the selected channel. It copies the live count into the output latch only if that latch is empty, and it leaves control, reload and byte-order state unchanged.
- R3: Data writes follow the access mode. Mode 1 loads {8'h00, byte}, mode 2 loads {byte, 8'h00}, and mode 3 takes the low byte first and commits {second, first} on the second write. Each commit pulses core_load for exactly the cycle after the strobe and updates core_reload at that cycle, and the reload value does not change otherwise.
- R4: A control byte with select 3 is a read-back command. Bits 1, 2 and 3 pick channels 0, 1 and 2, bit 4 set asks for a status latch and bit 5 set asks for a count latch. Each latch is captured only if it is empty.
- R5: A status byte holds the stored control bits 5:0 in bits 5:0, the core's null-count flag in bit 6 and the core's output level in bit 7, all sampled when the latch is taken.
- R6: A data read returns a pending status byte first and empties the status latch. Without one, it returns the output latch if full, else the live count. Mode 1 gives the low byte, mode 2 the high byte, and mode 3 alternates starting with the low byte. The output latch empties after a mode-3 high-byte read or any mode-1/2 read.
- R7: A control write as in R1 clears the reload value to zero, drops a pending low byte and resets the read byte order to low-first.
- R8: Mode codes 6 and 7 reach core_mode as 2 and 3.
- R9: After reset every channel is in access mode 1, mode 0, binary, and core_reload is zero. A read of the control port returns 8'hFF. Read data appears on host_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Single-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Offset: 0..2 channel data, 3 control |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after the strobe |
| core_load | output | NUM_CH | Per-channel count-commit pulse |
| core_setup | output | NUM_CH | Per-channel control-rewrite pulse |
| core_mode | output | 3*NUM_CH | Normalised mode per channel |
| core_bcd | output | NUM_CH | BCD counting flag per channel |
| core_reload | output | 16*NUM_CH | Reload value per channel |
| core_count | input | 16*NUM_CH | Live count from each core |
| core_out | input | NUM_CH | Output level from each core |
| core_null | input | NUM_CH | Null-count flag from each core |

## Verification
The bench builds the block with NUM_CH = 3 and RD_PIPE = 1. With three channels, every channel-select bit of the read-back command maps to a real channel, including the highest one. The registered read stage makes the read order and latch release observable one cycle after each strobe. Random mixes of control writes, latches, read-back commands, data writes and reads keep several channels in different access modes at once. Stub count and flag values change between accesses, so a latch that is wrongly refreshed or wrongly released shows up as a wrong byte.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = 2 * BYTE_W;
   localparam int ADDR_W = 2;
   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_LOHI  = 2'd3
   } acc_e;

   // bit order matters: status byte reuses these six bits verbatim
   typedef struct packed {
      acc_e              acc;
      logic [MODE_W-1:0] mode;
      logic              bcd;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{acc: ACC_LO, mode: 3'd0, bcd: 1'b0};

   // codes 6 and 7 alias modes 2 and 3
   function automatic logic [MODE_W-1:0] norm_mode(input logic [MODE_W-1:0] m);
      return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
   endfunction

   function automatic logic [BYTE_W-1:0] status_byte(input ctrl_t c,
                                                     input logic nul,
                                                     input logic lvl);
      return {lvl, nul, c};
   endfunction

endpackage

// File: rtl/ivt_cmd_decode.sv
module ivt_cmd_decode
   import ivt_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              host_sel,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [NUM_CH-1:0] cfg_wr,
   output logic [NUM_CH-1:0] cnt_latch,
   output logic [NUM_CH-1:0] sts_latch,
   output logic [NUM_CH-1:0] dat_wr,
   output logic [NUM_CH-1:0] dat_rd,
   output logic              ctl_rd
);

   localparam logic [ADDR_W-1:0] CTL_ADDR = '1;
   localparam logic [1:0]        RB_SEL   = 2'b11;

   logic       ctl_wr;
   logic [1:0] sel_f;
   logic [1:0] acc_f;
   logic       is_rb;

   assign ctl_wr = host_sel && host_we && (host_addr == CTL_ADDR);
   assign ctl_rd = host_sel && !host_we && (host_addr == CTL_ADDR);
   assign sel_f  = host_wdata[7:6];
   assign acc_f  = host_wdata[5:4];
   assign is_rb  = ctl_wr && (sel_f == RB_SEL);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic hit_ctl;
      logic rb_pick;
      assign hit_ctl       = ctl_wr && (sel_f == 2'(ch));
      assign rb_pick       = is_rb && host_wdata[ch+1];
      assign dat_wr[ch]    = host_sel && host_we  && (host_addr == ADDR_W'(ch));
      assign dat_rd[ch]    = host_sel && !host_we && (host_addr == ADDR_W'(ch));
      assign cfg_wr[ch]    = hit_ctl && (acc_f != 2'd0);
      assign cnt_latch[ch] = (hit_ctl && (acc_f == 2'd0)) || (rb_pick && host_wdata[5]);
      assign sts_latch[ch] = rb_pick && host_wdata[4];
   end

endmodule

// File: rtl/ivt_chan.sv
module ivt_chan
   import ivt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cnt_latch,
   input  logic              sts_latch,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic [CNT_W-1:0]  live_cnt,
   input  logic              live_out,
   input  logic              live_null,
   output ctrl_t             ctrl_o,
   output logic [CNT_W-1:0]  reload_o,
   output logic              load_o,
   output logic              setup_o,
   output logic [BYTE_W-1:0] rd_byte
);

   ctrl_t             ctrl_q;
   logic [CNT_W-1:0]  reload_q;
   logic              lo_pend_q;
   logic [BYTE_W-1:0] lo_q;
   logic              rd_hi_q;
   logic              ol_v_q;
   logic [CNT_W-1:0]  ol_q;
   logic              sl_v_q;
   logic [BYTE_W-1:0] sl_q;
   logic              load_q;
   logic              setup_q;

   logic [CNT_W-1:0]  src;
   logic              rd_hi_nxt;
   logic              ol_release;
   logic              commit;
   logic [CNT_W-1:0]  new_reload;

   assign src = ol_v_q ? ol_q : live_cnt;

   // read byte selection and byte-order bookkeeping
   always_comb begin
      rd_hi_nxt = rd_hi_q;
      rd_byte   = src[BYTE_W-1:0];
      if (sl_v_q) begin
         rd_byte = sl_q;
      end else begin
         unique case (ctrl_q.acc)
            ACC_HI:   rd_byte = src[CNT_W-1:BYTE_W];
            ACC_LOHI: begin
               rd_byte   = rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
               rd_hi_nxt = !rd_hi_q;
            end
            default:  rd_byte = src[BYTE_W-1:0];
         endcase
      end
      ol_release = !sl_v_q && !rd_hi_nxt;
   end

   // count assembly
   always_comb begin
      commit     = 1'b0;
      new_reload = reload_q;
      unique case (ctrl_q.acc)
         ACC_LO: begin
            commit     = 1'b1;
            new_reload = {{BYTE_W{1'b0}}, wbyte};
         end
         ACC_HI: begin
            commit     = 1'b1;
            new_reload = {wbyte, {BYTE_W{1'b0}}};
         end
         ACC_LOHI: begin
            commit     = lo_pend_q;
            new_reload = {wbyte, lo_q};
         end
         default: commit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= CTRL_RST;
         reload_q  <= '0;
         lo_pend_q <= 1'b0;
         lo_q      <= '0;
         rd_hi_q   <= 1'b0;
         ol_v_q    <= 1'b0;
         ol_q      <= '0;
         sl_v_q    <= 1'b0;
         sl_q      <= '0;
         load_q    <= 1'b0;
         setup_q   <= 1'b0;
      end else begin
         load_q  <= dat_wr && commit;
         setup_q <= cfg_wr;
         if (cfg_wr) begin
            ctrl_q    <= ctrl_t'(wbyte[5:0]);
            reload_q  <= '0;
            lo_pend_q <= 1'b0;
            rd_hi_q   <= 1'b0;
         end
         if (dat_wr) begin
            if (commit) begin
               reload_q <= new_reload;
            end
            if (ctrl_q.acc == ACC_LOHI) begin
               lo_pend_q <= !lo_pend_q;
               if (!lo_pend_q) begin
                  lo_q <= wbyte;
               end
            end
         end
         if (dat_rd) begin
            if (sl_v_q) begin
               sl_v_q <= 1'b0;
            end else begin
               rd_hi_q <= rd_hi_nxt;
               if (ol_release) begin
                  ol_v_q <= 1'b0;
               end
            end
         end
         if (cnt_latch && !ol_v_q) begin
            ol_v_q <= 1'b1;
            ol_q   <= live_cnt;
         end
         if (sts_latch && !sl_v_q) begin
            sl_v_q <= 1'b1;
            sl_q   <= status_byte(ctrl_q, live_null, live_out);
         end
      end
   end

   assign ctrl_o   = ctrl_q;
   assign reload_o = reload_q;
   assign load_o   = load_q;
   assign setup_o  = setup_q;

endmodule

// File: rtl/ivt_host_regfile.sv
module ivt_host_regfile
   import ivt_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int RD_PIPE = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_sel,
   input  logic                     host_we,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic [BYTE_W-1:0]        host_wdata,
   output logic [BYTE_W-1:0]        host_rdata,
   output logic [NUM_CH-1:0]        core_load,
   output logic [NUM_CH-1:0]        core_setup,
   output logic [NUM_CH*MODE_W-1:0] core_mode,
   output logic [NUM_CH-1:0]        core_bcd,
   output logic [NUM_CH*CNT_W-1:0]  core_reload,
   input  logic [NUM_CH*CNT_W-1:0]  core_count,
   input  logic [NUM_CH-1:0]        core_out,
   input  logic [NUM_CH-1:0]        core_null
);

   localparam logic [BYTE_W-1:0] CTL_RD_VAL = '1;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("NUM_CH must be 1..3");
   end
   if (RD_PIPE < 0 || RD_PIPE > 1) begin : g_bad_pipe
      $error("RD_PIPE must be 0 or 1");
   end

   logic [NUM_CH-1:0] cfg_wr;
   logic [NUM_CH-1:0] cnt_latch;
   logic [NUM_CH-1:0] sts_latch;
   logic [NUM_CH-1:0] dat_wr;
   logic [NUM_CH-1:0] dat_rd;
   logic              ctl_rd;
   logic [BYTE_W-1:0] ch_byte [NUM_CH];
   logic [BYTE_W-1:0] rd_now;

   ivt_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .host_sel   (host_sel),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .cfg_wr     (cfg_wr),
      .cnt_latch  (cnt_latch),
      .sts_latch  (sts_latch),
      .dat_wr     (dat_wr),
      .dat_rd     (dat_rd),
      .ctl_rd     (ctl_rd)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      ctrl_t ctrl_w;
      ivt_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_wr    (cfg_wr[ch]),
         .cnt_latch (cnt_latch[ch]),
         .sts_latch (sts_latch[ch]),
         .dat_wr    (dat_wr[ch]),
         .dat_rd    (dat_rd[ch]),
         .wbyte     (host_wdata),
         .live_cnt  (core_count[ch*CNT_W +: CNT_W]),
         .live_out  (core_out[ch]),
         .live_null (core_null[ch]),
         .ctrl_o    (ctrl_w),
         .reload_o  (core_reload[ch*CNT_W +: CNT_W]),
         .load_o    (core_load[ch]),
         .setup_o   (core_setup[ch]),
         .rd_byte   (ch_byte[ch])
      );
      assign core_mode[ch*MODE_W +: MODE_W] = norm_mode(ctrl_w.mode);
      assign core_bcd[ch]                   = ctrl_w.bcd;
   end

   always_comb begin
      rd_now = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (dat_rd[ch]) begin
            rd_now = ch_byte[ch];
         end
      end
      if (ctl_rd) begin
         rd_now = CTL_RD_VAL;
      end
   end

   if (RD_PIPE == 1) begin : g_rd_reg
      logic [BYTE_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else if (host_sel && !host_we) begin
            rdata_q <= rd_now;
         end
      end
      assign host_rdata = rdata_q;
   end else begin : g_rd_comb
      assign host_rdata = rd_now;
   end

endmodule

// File: rtl/ivt_host_regfile_chk.sv
module ivt_host_regfile_chk
   import ivt_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int RD_PIPE = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     host_sel,
   input logic                     host_we,
   input logic [ADDR_W-1:0]        host_addr,
   input logic [BYTE_W-1:0]        host_wdata,
   input logic [BYTE_W-1:0]        host_rdata,
   input logic [NUM_CH-1:0]        core_load,
   input logic [NUM_CH-1:0]        core_setup,
   input logic [NUM_CH*MODE_W-1:0] core_mode,
   input logic [NUM_CH*CNT_W-1:0]  core_reload
);

   AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_load));  // R3

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         core_load[ch] |-> $past(host_sel && host_we && host_addr == ADDR_W'(ch)));  // R3
      AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (!core_load[ch] && !core_setup[ch]) |-> $stable(core_reload[ch*CNT_W +: CNT_W]));  // R3
      AST_SETUP_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
         core_setup[ch] |-> $past(host_sel && host_we && host_addr == 2'd3 &&
                                  host_wdata[7:6] == 2'(ch) && host_wdata[5:4] != 2'd0));  // R1
      AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         core_setup[ch] |-> (core_reload[ch*CNT_W +: CNT_W] == '0));  // R7
      AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         core_mode[ch*MODE_W +: MODE_W] <= 3'd5);  // R8
   end

   if (RD_PIPE == 1) begin : g_rd
      AST_CTL_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
         $past(host_sel && !host_we && host_addr == 2'd3) |-> (host_rdata == 8'hFF));  // R9
   end

endmodule

bind ivt_host_regfile ivt_host_regfile_chk #(.NUM_CH(NUM_CH), .RD_PIPE(RD_PIPE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_sel    (host_sel),
   .host_we     (host_we),
   .host_addr   (host_addr),
   .host_wdata  (host_wdata),
   .host_rdata  (host_rdata),
   .core_load   (core_load),
   .core_setup  (core_setup),
   .core_mode   (core_mode),
   .core_reload (core_reload)
);

// File: tb/tb_ivt_host_regfile.sv
module tb_ivt_host_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [2:0]  core_load;
   logic [2:0]  core_setup;
   logic [8:0]  core_mode;
   logic [2:0]  core_bcd;
   logic [47:0] core_reload;
   logic [47:0] core_count;
   logic [2:0]  core_out;
   logic [2:0]  core_null;

   // counting-core stub: values the bench sets between accesses
   logic [15:0] cnt [3];
   logic [2:0]  outb = 3'b000;
   logic [2:0]  nulb = 3'b111;

   always_comb begin
      for (int i = 0; i < 3; i++) core_count[i*16 +: 16] = cnt[i];
   end
   assign core_out  = outb;
   assign core_null = nulb;

   always #2 clk = ~clk;

   ivt_host_regfile #(.NUM_CH(3), .RD_PIPE(1)) dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .core_load(core_load), .core_setup(core_setup), .core_mode(core_mode),
      .core_bcd(core_bcd), .core_reload(core_reload), .core_count(core_count),
      .core_out(core_out), .core_null(core_null)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // expected-state model
   logic [5:0]  m_ctrl [3];
   logic [15:0] m_reload [3];
   logic        m_lop [3];
   logic [7:0]  m_lo [3];
   logic        m_rdhi [3];
   logic        m_olv [3];
   logic [15:0] m_ol [3];
   logic        m_slv [3];
   logic [7:0]  m_sl [3];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_mode(input logic [2:0] m);
      return (m == 3'd6) ? 3'd2 : (m == 3'd7) ? 3'd3 : m;
   endfunction

   task automatic mdl_ctrl(input logic [7:0] d, output logic [2:0] setup);
      setup = '0;
      if (d[7:6] == 2'd3) begin
         for (int c = 0; c < 3; c++) begin
            if (d[c+1]) begin
               if (d[4] && !m_slv[c]) begin
                  m_slv[c] = 1'b1;
                  m_sl[c]  = {outb[c], nulb[c], m_ctrl[c]};
               end
               if (d[5] && !m_olv[c]) begin
                  m_olv[c] = 1'b1;
                  m_ol[c]  = cnt[c];
               end
            end
         end
      end else if (d[5:4] == 2'd0) begin
         if (!m_olv[d[7:6]]) begin
            m_olv[d[7:6]] = 1'b1;
            m_ol[d[7:6]]  = cnt[d[7:6]];
         end
      end else begin
         m_ctrl[d[7:6]]   = d[5:0];
         m_reload[d[7:6]] = '0;
         m_lop[d[7:6]]    = 1'b0;
         m_rdhi[d[7:6]]   = 1'b0;
         setup[d[7:6]]    = 1'b1;
      end
   endtask

   task automatic mdl_dwr(input int c, input logic [7:0] d, output logic [2:0] load);
      load = '0;
      case (m_ctrl[c][5:4])
         2'd1: begin m_reload[c] = {8'h00, d}; load[c] = 1'b1; end
         2'd2: begin m_reload[c] = {d, 8'h00}; load[c] = 1'b1; end
         default: begin
            if (m_lop[c]) begin
               m_reload[c] = {d, m_lo[c]};
               m_lop[c]    = 1'b0;
               load[c]     = 1'b1;
            end else begin
               m_lo[c]  = d;
               m_lop[c] = 1'b1;
            end
         end
      endcase
   endtask

   function automatic logic [7:0] mdl_rd(input int a);
      logic [15:0] s;
      logic [7:0]  b;
      if (a == 3) return 8'hFF;
      if (m_slv[a]) begin
         m_slv[a] = 1'b0;
         return m_sl[a];
      end
      s = m_olv[a] ? m_ol[a] : cnt[a];
      case (m_ctrl[a][5:4])
         2'd1: b = s[7:0];
         2'd2: b = s[15:8];
         default: begin
            m_rdhi[a] = !m_rdhi[a];
            b = m_rdhi[a] ? s[7:0] : s[15:8];
         end
      endcase
      if (!m_rdhi[a]) m_olv[a] = 1'b0;
      return b;
   endfunction

   task automatic do_wr(input string req, input logic [1:0] a, input logic [7:0] d);
      logic [2:0] e_load;
      logic [2:0] e_setup;
      e_load  = '0;
      e_setup = '0;
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      if (a == 2'd3) mdl_ctrl(d, e_setup);
      else           mdl_dwr(int'(a), d, e_load);
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0;
      chk({req, "/R3 load"}, 32'(core_load), 32'(e_load));
      chk({req, "/R1 setup"}, 32'(core_setup), 32'(e_setup));
      for (int c = 0; c < 3; c++) begin
         chk({req, "/R3 reload"}, 32'(core_reload[c*16 +: 16]), 32'(m_reload[c]));
         chk({req, "/R8 mode"}, 32'(core_mode[c*3 +: 3]), 32'(exp_mode(m_ctrl[c][3:1])));
         chk({req, "/R1 bcd"}, 32'(core_bcd[c]), 32'(m_ctrl[c][0]));
      end
   endtask

   task automatic do_rd(input string req, input logic [1:0] a);
      logic [7:0] e;
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b0; host_addr = a;
      e = mdl_rd(int'(a));
      @(negedge clk);
      host_sel = 1'b0;
      chk({req, "/R6 rdata"}, 32'(host_rdata), 32'(e));
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd7351);
      for (int c = 0; c < 3; c++) begin
         cnt[c] = '0; m_ctrl[c] = 6'b01_000_0; m_reload[c] = '0; m_lop[c] = 0;
         m_lo[c] = '0; m_rdhi[c] = 0; m_olv[c] = 0; m_ol[c] = '0; m_slv[c] = 0; m_sl[c] = '0;
      end
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 rst rdata", 32'(host_rdata), 32'h0);
      chk("R9 rst load", 32'(core_load), 32'h0);
      chk("R9 rst mode", 32'(core_mode), 32'h0);
      chk("R9 rst bcd", 32'(core_bcd), 32'h0);
      chk("R9 rst reload", 32'(core_reload == '0), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 default low-byte access, control port read
      cnt[0] = 16'h1234;
      do_rd("R9 default", 2'd0);
      chk("R9 low byte", 32'(host_rdata), 32'h34);
      do_rd("R9 ctl", 2'd3);
      chk("R9 ctl FF", 32'(host_rdata), 32'hFF);

      // R1 control word fields
      do_wr("R1 ctl", 2'd3, {2'd1, 2'd3, 3'd3, 1'b1});
      chk("R1 mode ch1", 32'(core_mode[5:3]), 32'd3);
      // R3 two-byte write
      do_wr("R3 lo", 2'd1, 8'hCD);
      do_wr("R3 hi", 2'd1, 8'hAB);
      chk("R3 reload ABCD", 32'(core_reload[31:16]), 32'hABCD);
      do_wr("R3 ctl lo", 2'd3, {2'd2, 2'd1, 3'd0, 1'b0});
      do_wr("R3 lo only", 2'd2, 8'h5A);
      chk("R3 reload 005A", 32'(core_reload[47:32]), 32'h005A);
      do_wr("R3 ctl hi", 2'd3, {2'd2, 2'd2, 3'd0, 1'b0});
      do_wr("R3 hi only", 2'd2, 8'h5A);
      chk("R3 reload 5A00", 32'(core_reload[47:32]), 32'h5A00);

      // R2 counter latch, second latch ignored
      cnt[1] = 16'h4321;
      do_wr("R2 latch", 2'd3, 8'h40);
      cnt[1] = 16'h9999;
      do_wr("R2 relatch", 2'd3, 8'h40);
      do_rd("R2 lo", 2'd1);
      chk("R2 latched lo", 32'(host_rdata), 32'h21);
      do_rd("R2 hi", 2'd1);
      chk("R2 latched hi", 32'(host_rdata), 32'h43);
      do_rd("R2 live", 2'd1);
      chk("R2 released", 32'(host_rdata), 32'h99);
      do_rd("R2 live hi", 2'd1);

      // R8 mode aliases
      do_wr("R8 m6", 2'd3, {2'd0, 2'd3, 3'd6, 1'b0});
      chk("R8 6->2", 32'(core_mode[2:0]), 32'd2);
      do_wr("R8 m7", 2'd3, {2'd0, 2'd3, 3'd7, 1'b1});
      chk("R8 7->3", 32'(core_mode[2:0]), 32'd3);

      // R4/R5 read-back on channels 0 and 2, status before count
      outb = 3'b101; nulb = 3'b110;
      cnt[0] = 16'h0102; cnt[2] = 16'h0304;
      do_wr("R4 rb", 2'd3, 8'hFB);
      cnt[0] = 16'hEEEE; cnt[2] = 16'hDDDD; outb = 3'b000;
      do_rd("R5 sts0", 2'd0);
      chk("R5 status ch0", 32'(host_rdata), 32'h80 | 32'h3F);
      do_rd("R6 cnt0 lo", 2'd0);
      chk("R6 latched lo", 32'(host_rdata), 32'h02);
      do_rd("R6 cnt0 hi", 2'd0);
      chk("R6 latched hi", 32'(host_rdata), 32'h01);
      do_rd("R5 sts2", 2'd2);
      chk("R5 status ch2", 32'(host_rdata), 32'hE0);
      do_rd("R6 cnt2", 2'd2);
      chk("R6 latched hi ch2", 32'(host_rdata), 32'h03);
      do_rd("R4 ch1 untouched", 2'd1);

      // R7 control write clears pending low byte and read order
      do_wr("R7 lo", 2'd0, 8'h11);
      do_rd("R7 rd lo", 2'd0);
      do_wr("R7 ctl", 2'd3, {2'd0, 2'd3, 3'd2, 1'b0});
      chk("R7 reload cleared", 32'(core_reload[15:0]), 32'h0);
      do_rd("R7 order reset", 2'd0);
      chk("R7 low first", 32'(host_rdata), 32'hEE);
      do_rd("R7 hi", 2'd0);
      do_wr("R7 new lo", 2'd0, 8'h22);
      chk("R7 no load", 32'(core_load), 32'h0);
      do_wr("R7 new hi", 2'd0, 8'h33);
      chk("R7 reload 3322", 32'(core_reload[15:0]), 32'h3322);

      // constrained random mix
      for (int it = 0; it < 600; it++) begin
         int op;
         int ch;
         op = int'($urandom % 12);
         ch = int'($urandom % 3);
         if (($urandom % 4) == 0) begin
            cnt[ch] = 16'($urandom);
            outb[ch] = 1'($urandom);
            nulb[ch] = 1'($urandom);
         end
         if (op < 2)
            do_wr("R1 rnd ctl", 2'd3, {2'(ch), 2'(1 + $urandom % 3), 3'($urandom), 1'($urandom)});
         else if (op == 2)
            do_wr("R2 rnd latch", 2'd3, {2'(ch), 6'h00});
         else if (op == 3)
            do_wr("R4 rnd rb", 2'd3, {2'b11, 6'($urandom)});
         else if (op < 7)
            do_wr("R3 rnd data", 2'(ch), 8'($urandom));
         else
            do_rd("R6 rnd read", 2'($urandom % 4));
      end

      summary();
   end

endmodule